// File: doc/BRIEF.md
# Two-Rail Transition-Coded Serial Link

This block is a matched transmitter and receiver that carry one data bit per clock over two binary wires. One wire is a strobe that changes level on every clock. The other wire is a data wire in NRZI form: it changes level for a 1 and keeps its level for a 0. The receiver looks only at which wires changed in each interval. Because of this, it decodes correctly when the two wires are swapped, when either wire is inverted, or when both happen, and it needs no setting to tell it which case applies.

For verification, the top level also contains a channel model. The channel has static controls for swap and for inverting each wire. It also has a freeze control that holds the received levels, which is how a stalled line is modelled. A two-stage reset sequencer marks the start-up window during which the output is not yet valid. The decoded bit appears two clocks after the bit entered. A sticky error flag reports any interval after start-up in which neither received wire changed.

Top module: `tworail_link`

## Requirements
- R1: From the first clock edge after `rst_i` is released, `line_a` (the strobe rail) changes level on every clock edge, whatever `din` is.
- R2: `line_b` (the data rail) changes level at a clock edge exactly when the `din` sampled at that edge is 1, and keeps its level when it is 0.
- R3: At every clock edge after release, at least one of `line_a` and `line_b` changes level.
- R4: Decoding is correct for all eight channel settings given by `{ch_swap, ch_inv_a, ch_inv_b}`. `ch_swap`=1 feeds receive wire A from `line_b` and receive wire B from `line_a`. `ch_inv_a` and `ch_inv_b` invert receive wires A and B.
- R5: Once `link_busy` is low and no line error has been flagged, `dout` in each cycle equals the `din` value of two cycles earlier.
- R6: `link_busy` is high while `rst_i` is high. After release it stays high through the first clock edge, goes low at the second, and then stays low.
- R7: When neither received wire changes over an interval while `link_busy` is low, `line_err` goes to 1 at that clock edge. It then stays at 1 until `rst_i` is asserted. `ch_freeze`=1 holds both received wires at their last levels, so it produces this error one edge later.
- R8: While `rst_i` is high, the outputs are `line_a`=0, `line_b`=0, `dout`=0, `line_err`=0 and `link_busy`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one baud interval per cycle |
| rst_i | input | 1 | Asynchronous reset, active high |
| din | input | 1 | Serial data bit sampled each clock |
| ch_swap | input | 1 | Channel model: cross the two wires |
| ch_inv_a | input | 1 | Channel model: invert receive wire A |
| ch_inv_b | input | 1 | Channel model: invert receive wire B |
| ch_freeze | input | 1 | Channel model: hold both received wires (stall) |
| line_a | output | 1 | Transmit strobe rail |
| line_b | output | 1 | Transmit NRZI data rail |
| dout | output | 1 | Decoded serial data, two cycles after `din` |
| link_busy | output | 1 | High during the reset sequence window |
| line_err | output | 1 | Sticky flag: an interval with no rail change |

## Verification
Suppose a stale receive register, a wrong change-detect term or a decode that depends on polarity. Any of these shows up at `dout` in the first interval where the affected wire's change pattern matters. With pseudo-random data, that is almost always within a few cycles after `link_busy` falls, and only under some channel settings, so every setting is swept. A transmitter rail that stops toggling, or that follows the wrong data sense, shows directly on `line_a`/`line_b` at the next edge. It also raises `line_err` or corrupts `dout` two cycles later. A reset sequencer that is one stage off moves the fall of `link_busy` by a cycle, and the check on the second edge after release catches it.

// File: rtl/tworail_pkg.sv
package tworail_pkg;

  typedef struct packed {
    logic data;    // NRZI data rail
    logic strobe;  // always-toggling rail
  } rails_t;

  // next transmit rail levels for one baud interval
  function automatic rails_t next_rails(input rails_t cur, input logic bitv);
    rails_t n;
    n.strobe = ~cur.strobe;
    n.data   = cur.data ^ bitv;
    return n;
  endfunction

  // one received wire after static crossing and inversion
  function automatic logic perturb(input logic own, input logic other,
                                   input logic swap, input logic inv);
    return (swap ? other : own) ^ inv;
  endfunction

  // both wires moved -> 1, exactly one moved -> 0
  function automatic logic decode_bit(input logic chg_a, input logic chg_b);
    return chg_a & chg_b;
  endfunction

  function automatic logic rails_stalled(input logic chg_a, input logic chg_b);
    return ~(chg_a | chg_b);
  endfunction

endpackage

// File: rtl/tworail_rst_seq.sv
module tworail_rst_seq #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_i,
  output logic busy
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) chain_q <= '1;
    else       chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign busy = |chain_q;

  p_busy_stays_low_r6: assert property (@(posedge clk) disable iff (rst_i)
    !busy |=> !busy);
endmodule

// File: rtl/tworail_tx.sv
module tworail_tx
  import tworail_pkg::*;
(
  input  logic clk,
  input  logic rst_i,
  input  logic din,
  output logic line_a,
  output logic line_b
);
  rails_t rails_q;

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) rails_q <= '0;
    else       rails_q <= next_rails(rails_q, din);
  end

  assign line_a = rails_q.strobe;
  assign line_b = rails_q.data;
endmodule

// File: rtl/tworail_chan.sv
module tworail_chan
  import tworail_pkg::*;
(
  input  logic clk,
  input  logic rst_i,
  input  logic tx_a,
  input  logic tx_b,
  input  logic swap,
  input  logic inv_a,
  input  logic inv_b,
  input  logic freeze,
  output logic rx_a,
  output logic rx_b
);
  logic live_a, live_b;
  logic held_a_q, held_b_q;

  assign live_a = perturb(tx_a, tx_b, swap, inv_a);
  assign live_b = perturb(tx_b, tx_a, swap, inv_b);
  assign rx_a   = freeze ? held_a_q : live_a;
  assign rx_b   = freeze ? held_b_q : live_b;

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) begin
      held_a_q <= 1'b0;
      held_b_q <= 1'b0;
    end else begin
      held_a_q <= rx_a;
      held_b_q <= rx_b;
    end
  end

  p_freeze_holds_r7: assert property (@(posedge clk) disable iff (rst_i)
    ($past(freeze) && freeze) |-> ($stable(rx_a) && $stable(rx_b)));
endmodule

// File: rtl/tworail_rx.sv
module tworail_rx
  import tworail_pkg::*;
(
  input  logic clk,
  input  logic rst_i,
  input  logic busy,
  input  logic rx_a,
  input  logic rx_b,
  output logic dout,
  output logic line_err
);
  logic prev_a_q, prev_b_q;
  logic chg_a, chg_b;
  logic dout_q, err_q;

  assign chg_a = rx_a ^ prev_a_q;
  assign chg_b = rx_b ^ prev_b_q;

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) begin
      prev_a_q <= 1'b0;
      prev_b_q <= 1'b0;
      dout_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      prev_a_q <= rx_a;
      prev_b_q <= rx_b;
      dout_q   <= decode_bit(chg_a, chg_b);
      if (!busy && rails_stalled(chg_a, chg_b)) err_q <= 1'b1;
    end
  end

  assign dout     = dout_q;
  assign line_err = err_q;

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst_i)
    line_err |=> line_err);
  p_err_cause_r7: assert property (@(posedge clk) disable iff (rst_i)
    $rose(line_err) |-> ($past(!chg_a && !chg_b) && !$past(busy)));
endmodule

// File: rtl/tworail_link.sv
module tworail_link #(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_i,
  input  logic din,
  input  logic ch_swap,
  input  logic ch_inv_a,
  input  logic ch_inv_b,
  input  logic ch_freeze,
  output logic line_a,
  output logic line_b,
  output logic dout,
  output logic link_busy,
  output logic line_err
);
  logic rx_a, rx_b;

  tworail_rst_seq #(.STAGES(RST_STAGES)) u_seq (
    .clk(clk), .rst_i(rst_i), .busy(link_busy)
  );

  tworail_tx u_tx (
    .clk(clk), .rst_i(rst_i), .din(din), .line_a(line_a), .line_b(line_b)
  );

  tworail_chan u_chan (
    .clk(clk), .rst_i(rst_i), .tx_a(line_a), .tx_b(line_b),
    .swap(ch_swap), .inv_a(ch_inv_a), .inv_b(ch_inv_b), .freeze(ch_freeze),
    .rx_a(rx_a), .rx_b(rx_b)
  );

  tworail_rx u_rx (
    .clk(clk), .rst_i(rst_i), .busy(link_busy), .rx_a(rx_a), .rx_b(rx_b),
    .dout(dout), .line_err(line_err)
  );

  p_strobe_toggle_r1: assert property (@(posedge clk) disable iff (rst_i)
    !link_busy |-> (line_a != $past(line_a)));
  p_nrzi_rail_r2: assert property (@(posedge clk) disable iff (rst_i)
    !link_busy |-> ((line_b ^ $past(line_b)) == $past(din)));
  p_rail_moves_r3: assert property (@(posedge clk) disable iff (rst_i)
    !link_busy |-> ((line_a != $past(line_a)) || (line_b != $past(line_b))));
  p_latency_r5: assert property (@(posedge clk) disable iff (rst_i)
    (!link_busy && !line_err) |-> (dout == $past(din, 2)));
endmodule

// File: tb/tworail_link_tb.sv
module tworail_link_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_i = 1'b1, din = 1'b0;
  logic ch_swap = 1'b0, ch_inv_a = 1'b0, ch_inv_b = 1'b0, ch_freeze = 1'b0;
  logic line_a, line_b, dout, link_busy, line_err;

  tworail_link u_dut (
    .clk(clk), .rst_i(rst_i), .din(din), .ch_swap(ch_swap),
    .ch_inv_a(ch_inv_a), .ch_inv_b(ch_inv_b), .ch_freeze(ch_freeze),
    .line_a(line_a), .line_b(line_b), .dout(dout),
    .link_busy(link_busy), .line_err(line_err)
  );

  int checks = 0, errors = 0, since = 0;
  logic d1 = 1'b0, d2 = 1'b0, prev_a = 1'b0, prev_b = 1'b0;
  logic skip_dout = 1'b0;
  logic [6:0] lfsr = 7'h5A;
  bit done = 0;

  function automatic logic exp_strobe(input logic prev);
    return ~prev;
  endfunction
  function automatic logic exp_data(input logic prev, input logic bitv);
    return bitv ? ~prev : prev;
  endfunction
  function automatic logic [6:0] prbs_step(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

  task automatic check_eq(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  // negedge: check outputs, then drive the next bit
  task automatic step(input logic bitv);
    @(negedge clk);
    if (since >= 1) begin
      check_eq("R1 strobe toggles", line_a, exp_strobe(prev_a));
      check_eq("R2 nrzi data rail", line_b, exp_data(prev_b, d1));
      check_eq("R3 a rail moves", (line_a != prev_a) || (line_b != prev_b), 1'b1);
    end
    if (since == 1) check_eq("R6 busy after first edge", link_busy, 1'b1);
    if (since >= 2) check_eq("R6 busy low", link_busy, 1'b0);
    if (since >= 2 && !skip_dout) begin
      check_eq("R4/R5 dout two cycles late", dout, d2);
      check_eq("R7 no error on clean link", line_err, 1'b0);
    end
    prev_a = line_a; prev_b = line_b;
    d2 = d1; d1 = bitv; din = bitv;
    since++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_i = 1'b1; din = 1'b0; ch_freeze = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_eq("R8 line_a reset", line_a, 1'b0);
    check_eq("R8 line_b reset", line_b, 1'b0);
    check_eq("R8 dout reset", dout, 1'b0);
    check_eq("R8 line_err reset", line_err, 1'b0);
    check_eq("R8 busy in reset", link_busy, 1'b1);
    rst_i = 1'b0; din = 1'b0;
    d1 = 1'b0; d2 = 1'b0; prev_a = 1'b0; prev_b = 1'b0;
    skip_dout = 1'b0;
    since = 1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R4: every channel setting with PRBS data
    for (int c = 0; c < 8; c++) begin
      {ch_swap, ch_inv_a, ch_inv_b} = c[2:0];
      do_reset();
      for (int i = 0; i < 60; i++) begin
        lfsr = prbs_step(lfsr);
        step(lfsr[0]);
      end
    end
    // random setting, random data, then directed runs
    {ch_swap, ch_inv_a, ch_inv_b} = 3'($urandom % 8);
    do_reset();
    for (int i = 0; i < 40; i++) step(1'($urandom % 2));
    for (int i = 0; i < 12; i++) step(1'b1);
    for (int i = 0; i < 12; i++) step(1'b0);
    for (int i = 0; i < 8; i++)  step(1'(i % 2));
    // R7: stalled channel raises a sticky error
    {ch_swap, ch_inv_a, ch_inv_b} = 3'b101;
    do_reset();
    for (int i = 0; i < 6; i++) step(1'($urandom % 2));
    @(negedge clk);
    skip_dout = 1'b1;
    ch_freeze = 1'b1;
    @(negedge clk);
    check_eq("R7 error on stall", line_err, 1'b1);
    ch_freeze = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      din = 1'($urandom % 2);
      check_eq("R7 error sticky", line_err, 1'b1);
    end
    do_reset();
    step(1'b1);
    step(1'b0);
    step(1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule